// File: doc/BRIEF.md
# Clock-Enable Suspend and Power-Down Controller

This block handles the clock-enable input on the device side of a two-bank synchronous DRAM. On every rising clock edge it samples the clock-enable pin together with the decoded command. From these it produces a per-edge qualifier that tells the command decoder and the burst engine whether this edge counts.

When clock-enable drops while a read or write burst is running, the block freezes the burst where it stands. This is clock-suspend. When clock-enable drops with no burst running, the block enters power-down instead. The two exit paths have different latencies. A suspend resumes on the second high edge. A power-down accepts a command on the first high edge.

The block tracks which banks hold an open row. It flags the lowest-power condition when it is powered down with every bank closed. It also keeps a small burst position counter so that the freeze can be seen at its ports.

Top module: `cke_suspend_ctrl`

## Requirements
- R1: After reset the block is in normal operation. `suspendActive`, `powerdownActive`, `minPower` and `burstActive` are all 0, `burstPos` is 0, and every bank is closed.
- R2: `cmdAcceptEn` is high in a cycle only when `cke` is high and the block is either running normally or completing an exit in that cycle. It is always low while `cke` is low.
- R3: If `cke` is sampled low while a burst is active, `suspendActive` is 1 after that edge. `burstPos` and `burstActive` then hold their values until the suspend is exited.
- R4: If `cke` is sampled low in normal operation with no burst active, `powerdownActive` is 1 after that edge. `suspendActive` and `powerdownActive` are never both 1.
- R5: Commands presented on an edge where `cmdAcceptEn` is low have no effect on the bank state or on the burst.
- R6: Leaving suspend takes two consecutive edges with `cke` high. The first edge keeps the block suspended. The second edge is accepted and the burst advances. A low sample in between restarts the count.
- R7: Leaving power-down takes one edge. The first edge with `cke` high accepts its command, and `powerdownActive` is 0 after it.
- R8: `minPower` is 1 exactly when `powerdownActive` is 1 and no bank is open. The command codes are 0 no-op, 1 open row in `cmdBank`, 4 close `cmdBank`, and 5 close all banks.
- R9: An accepted read (code 2) or write (code 3) starts a burst at position 0, including when it interrupts a running burst. Each later enabled edge advances the position by one. After the edge that leaves position BURST_LEN-1, `burstActive` is 0 and `burstPos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable pin |
| cmdCode | input | 3 | Decoded command code |
| cmdBank | input | BANK_W (1) | Bank addressed by the command |
| cmdAcceptEn | output | 1 | This edge is accepted (combinational) |
| suspendActive | output | 1 | Burst frozen by clock-suspend |
| powerdownActive | output | 1 | Power-down state |
| minPower | output | 1 | Power-down with all banks closed |
| burstActive | output | 1 | A burst is in progress |
| burstPos | output | POS_W (2) | Current position within the burst |

## Verification
`cmdAcceptEn` is due in the same cycle as the inputs that drive it. The bench drives on the falling edge and compares this output one time unit later, before the rising edge samples anything. Every registered output is due one rising edge after the stimulus. The driver pushes those expected values into a queue, and the monitor pops and compares them two time units after that edge. The exit sequences are run edge by edge, so the second-edge resume and the counter restart are both observed at the exact cycle they take effect.

// File: rtl/cke_pkg.sv
package cke_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_DEAC = 3'd4,
    CMD_DALL = 3'd5
  } cmdCode_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SUSP = 2'd1,
    ST_PDN  = 2'd2
  } ckeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clkEn;   // this edge counts
    logic pdMode;  // currently powered down
  } ctrlStrobes_t;
endpackage

// File: rtl/cke_ctrl.sv
module cke_ctrl
  import cke_pkg::*;
#(
  parameter int SUSP_EXIT_EDGES = 2,
  parameter int PD_EXIT_EDGES   = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cke,
  input  logic         burstActive,
  output ctrlStrobes_t strobes,
  output logic         suspendActive,
  output logic         powerdownActive
);
  localparam int MAX_EDGES = (SUSP_EXIT_EDGES > PD_EXIT_EDGES) ? SUSP_EXIT_EDGES : PD_EXIT_EDGES;
  localparam int CNT_W     = $clog2(MAX_EDGES + 1);

  ckeState_t        state, stateNext;
  logic [CNT_W-1:0] exitCnt, exitCntNext, needCnt;
  logic             exitDone;

  always_comb begin
    needCnt  = (state == ST_SUSP) ? CNT_W'(SUSP_EXIT_EDGES - 1) : CNT_W'(PD_EXIT_EDGES - 1);
    exitDone = (exitCnt == needCnt);
  end

  always_comb begin
    stateNext   = state;
    exitCntNext = exitCnt;
    unique case (state)
      ST_RUN: begin
        exitCntNext = '0;
        if (!cke) stateNext = burstActive ? ST_SUSP : ST_PDN;
      end
      default: begin
        if (!cke) begin
          exitCntNext = '0;
        end else if (exitDone) begin
          exitCntNext = '0;
          stateNext   = ST_RUN;
        end else begin
          exitCntNext = exitCnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      exitCnt <= '0;
    end else begin
      state   <= stateNext;
      exitCnt <= exitCntNext;
    end
  end

  always_comb begin
    strobes.clkEn   = cke && ((state == ST_RUN) || exitDone);
    strobes.pdMode  = (state == ST_PDN);
    suspendActive   = (state == ST_SUSP);
    powerdownActive = (state == ST_PDN);
  end

  // R2: a low clock-enable never yields an accepted edge
  assert_no_accept_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> !strobes.clkEn);
  // R4: the two low-power states are exclusive
  assert_exclusive_states_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(suspendActive && powerdownActive));
  // R6: leaving suspend needs two high samples in a row
  assert_suspend_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(suspendActive) |-> $past(cke) && $past(cke, 2));
  // R3: entering suspend only happens with a running burst
  assert_suspend_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspendActive) |-> $past(burstActive) && !$past(cke));
endmodule

// File: rtl/cke_datapath.sv
module cke_datapath
  import cke_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int POS_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [2:0]        cmdCode,
  input  logic [BANK_W-1:0] cmdBank,
  output logic              burstActive,
  output logic [POS_W-1:0]  burstPos,
  output logic              minPower
);
  logic [NUM_BANKS-1:0] bankOpen;
  logic                 startBurst;

  assign startBurst = strobes.clkEn &&
                      ((cmdCode == CMD_RD) || (cmdCode == CMD_WR));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOpen[b] <= 1'b0;
      end else if (strobes.clkEn) begin
        if (cmdCode == CMD_ACT && cmdBank == BANK_W'(b))
          bankOpen[b] <= 1'b1;
        else if ((cmdCode == CMD_DEAC && cmdBank == BANK_W'(b)) || cmdCode == CMD_DALL)
          bankOpen[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      burstPos    <= '0;
    end else if (startBurst) begin
      burstActive <= 1'b1;
      burstPos    <= '0;
    end else if (strobes.clkEn && burstActive) begin
      if (burstPos == POS_W'(BURST_LEN - 1)) begin
        burstActive <= 1'b0;
        burstPos    <= '0;
      end else begin
        burstPos <= burstPos + 1'b1;
      end
    end
  end

  assign minPower = strobes.pdMode && (bankOpen == '0);

  // R3 / R5: without an enabled edge the burst does not move
  assert_burst_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clkEn |=> $stable(burstPos) && $stable(burstActive));
  // R5: bank state changes only on enabled edges
  assert_banks_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clkEn |=> $stable(bankOpen));
  // R8: the lowest-power flag implies power-down
  assert_min_in_pd_R8: assert property (@(posedge clk) disable iff (!rstN)
    minPower |-> strobes.pdMode);
endmodule

// File: rtl/cke_suspend_ctrl.sv
module cke_suspend_ctrl
  import cke_pkg::*;
#(
  parameter int NUM_BANKS       = 2,
  parameter int BURST_LEN       = 4,
  parameter int SUSP_EXIT_EDGES = 2,
  parameter int PD_EXIT_EDGES   = 1,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int POS_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic [2:0]        cmdCode,
  input  logic [BANK_W-1:0] cmdBank,
  output logic              cmdAcceptEn,
  output logic              suspendActive,
  output logic              powerdownActive,
  output logic              minPower,
  output logic              burstActive,
  output logic [POS_W-1:0]  burstPos
);
  ctrlStrobes_t strobes;

  cke_ctrl #(
    .SUSP_EXIT_EDGES(SUSP_EXIT_EDGES),
    .PD_EXIT_EDGES  (PD_EXIT_EDGES)
  ) i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cke            (cke),
    .burstActive    (burstActive),
    .strobes        (strobes),
    .suspendActive  (suspendActive),
    .powerdownActive(powerdownActive)
  );

  cke_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .BURST_LEN(BURST_LEN)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdCode    (cmdCode),
    .cmdBank    (cmdBank),
    .burstActive(burstActive),
    .burstPos   (burstPos),
    .minPower   (minPower)
  );

  assign cmdAcceptEn = strobes.clkEn;
endmodule

// File: tb/test_cke_suspend_ctrl.sv
module test_cke_suspend_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cke = 1'b1;
  logic [2:0] cmdCode = 3'd0;
  logic [0:0] cmdBank = 1'b0;
  logic       cmdAcceptEn, suspendActive, powerdownActive, minPower, burstActive;
  logic [1:0] burstPos;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic       s, p, m, ba;
    logic [1:0] pos;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  cke_suspend_ctrl i_cke_suspend_ctrl (
    .clk(clk), .rstN(rstN), .cke(cke), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .cmdAcceptEn(cmdAcceptEn), .suspendActive(suspendActive),
    .powerdownActive(powerdownActive), .minPower(minPower),
    .burstActive(burstActive), .burstPos(burstPos)
  );

  // monitor: compares registered outputs after each edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if ({suspendActive, powerdownActive, minPower, burstActive, burstPos} !==
          {e.s, e.p, e.m, e.ba, e.pos}) begin
        errors++;
        $display("FAIL %s: susp/pd/min/bact/pos actual=%b%b%b%b/%0d expected=%b%b%b%b/%0d",
                 e.tag, suspendActive, powerdownActive, minPower, burstActive, burstPos,
                 e.s, e.p, e.m, e.ba, e.pos);
      end
    end
  end

  task automatic step(input logic k, input logic [2:0] c, input logic b,
                      input logic expAcc, input logic s, input logic p,
                      input logic m, input logic ba, input logic [1:0] pos,
                      input string tag);
    expItem_t e;
    @(negedge clk);
    cke = k; cmdCode = c; cmdBank = b;
    #1;
    checks++;
    if (cmdAcceptEn !== expAcc) begin
      errors++;
      $display("FAIL %s (R2 accept): actual=%b expected=%b", tag, cmdAcceptEn, expAcc);
    end
    e.s = s; e.p = p; e.m = m; e.ba = ba; e.pos = pos; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({suspendActive, powerdownActive, minPower, burstActive, burstPos} !== 6'b0) begin
      errors++;
      $display("FAIL R1 reset: actual=%b expected=000000",
               {suspendActive, powerdownActive, minPower, burstActive, burstPos});
    end
    @(negedge clk); rstN = 1'b1;
    //    cke cmd bank acc s p m ba pos
    step(1, 0, 0, 1, 0,0,0,0,0, "R1 normal idle");
    step(0, 0, 0, 0, 0,1,1,0,0, "R4 enter power-down idle (R8 min)");
    step(0, 2, 0, 0, 0,1,1,0,0, "R5 read ignored in power-down");
    step(1, 1, 0, 1, 0,0,0,0,0, "R7 exit on first high edge, open bank0");
    step(0, 0, 0, 0, 0,1,0,0,0, "R8 power-down with row open not min");
    step(1, 2, 0, 1, 0,0,0,1,0, "R9 read starts burst (R7)");
    step(1, 0, 0, 1, 0,0,0,1,1, "R9 burst advances");
    step(0, 0, 0, 0, 1,0,0,1,1, "R3 suspend freezes burst");
    step(0, 3, 0, 0, 1,0,0,1,1, "R5 write ignored in suspend");
    step(1, 0, 0, 0, 1,0,0,1,1, "R6 first high edge still suspended");
    step(0, 0, 0, 0, 1,0,0,1,1, "R6 low restarts exit count");
    step(1, 0, 0, 0, 1,0,0,1,1, "R6 first high edge again");
    step(1, 0, 0, 1, 0,0,0,1,2, "R6 second high edge resumes");
    step(1, 0, 0, 1, 0,0,0,1,3, "R9 advance to last");
    step(1, 0, 0, 1, 0,0,0,0,0, "R9 burst ends");
    step(1, 4, 0, 1, 0,0,0,0,0, "R8 close bank0");
    step(0, 0, 0, 0, 0,1,1,0,0, "R8 min after close");
    step(1, 1, 1, 1, 0,0,0,0,0, "R7 exit, open bank1");
    step(1, 1, 0, 1, 0,0,0,0,0, "R8 open bank0");
    step(0, 0, 0, 0, 0,1,0,0,0, "R8 two rows open not min");
    step(1, 5, 0, 1, 0,0,0,0,0, "R8 close all banks");
    step(0, 0, 0, 0, 0,1,1,0,0, "R8 min after close-all");
    step(1, 0, 0, 1, 0,0,0,0,0, "R7 exit");
    step(1, 3, 1, 1, 0,0,0,1,0, "R9 write starts burst");
    step(1, 0, 0, 1, 0,0,0,1,1, "R9 advance");
    step(1, 2, 0, 1, 0,0,0,1,0, "R9 read interrupts burst");
    step(1, 0, 0, 1, 0,0,0,1,1, "R9 advance after interrupt");
    step(1, 0, 0, 1, 0,0,0,1,2, "R9 advance");
    step(1, 0, 0, 1, 0,0,0,1,3, "R9 last");
    step(1, 0, 0, 1, 0,0,0,0,0, "R9 end");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule